// File: doc/BRIEF.md
# Host-to-Buffer-RAM Prefetch/Write Cache

This block connects a host bus slave port, whose strobes arrive asynchronously, to a single-port local buffer RAM that is one byte wide. A small byte FIFO sits between the two sides. In read direction the FIFO holds bytes fetched ahead of the host. In write direction it holds host data that has been accepted but not yet written to RAM. Only one direction is active at a time.

Two counters track the data. The host counter holds the next address the host is expected to use. The buffer counter holds the next RAM address to fetch from, or to write to. An access whose address equals the host counter, in the matching direction, is a hit. Any other access is a miss, and it reloads both counters after the FIFO has been emptied or invalidated. The host may move one byte or one 16-bit word per access. Words are little-endian: the low byte sits at the lower address.

The host is stalled through a ready line with tri-state behaviour, which appears here as a driver enable `rdy_oe` and a driven level `rdy_val`. While the access is stalled the line is driven low. It is driven high once the access is serviced. It is released when the host strobe ends. The RAM side is offered an access only when `ram_free` was high in the previous cycle. RAM reads return data one cycle after the address.

Top module: `hbc_cache`

## Requirements
- R1: After synchronous reset, `rdy_oe`, `rdy_val`, `ram_re` and `ram_we` are low. No RAM read is issued until the host makes a read access.
- R2: A read miss loads both counters with the host address, and the returned data comes from that address. A word read returns {byte[A+1], byte[A]} on `host_rdata[15:0]`. A byte read returns byte[A] on bits 7:0, with bits 15:8 zero.
- R3: When an access cannot be serviced at once, `rdy_oe`=1 and `rdy_val`=0. Once the access is serviced, `rdy_val`=1 and stays at 1 while the strobe is held. Both signals are low three clock edges after the strobe is removed.
- R4: A read whose address equals the host counter, with enough valid prefetched bytes, completes without a stall. `rdy_oe` and `rdy_val` rise together on the third clock edge after the strobe is applied.
- R5: After each serviced access the host counter advances by 1 for a byte access and by 2 for a word access. The counter wraps modulo 2^AW, so sequential accesses across the top address still hit.
- R6: In read direction the block fetches ahead only while the FIFO has room. After a read miss in which the host consumes one byte, and with no further access, exactly 5 RAM reads take place.
- R7: A write hit with enough free FIFO slots completes without a stall, with the same timing as R4. Posted bytes are written to RAM at sequential addresses, and the final RAM image matches every host write.
- R8: On a write miss while posted bytes remain, the host stays stalled and no new address is used until all posted bytes are written. The old bytes reach RAM before the new ones.
- R9: A read that follows posted writes is treated as a miss. Pending writes are flushed before prefetching starts, so the read returns the newly written data.
- R10: A read miss in read direction discards unconsumed prefetched bytes and returns the data at the new address.
- R11: A word access completes only when two valid bytes are present (read) or two free slots exist (write). Otherwise it stalls as in R3.
- R12: `ram_re` or `ram_we` is asserted only in a cycle that follows a cycle with `ram_free` high. While `ram_free` stays low, no RAM access takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RAM-side clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe, asynchronous, active high |
| host_wr | input | 1 | Host write strobe, asynchronous, active high |
| host_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 2*DW | Host write data, low byte at lower address |
| host_rdata | output | 2*DW | Host read data, valid while `rdy_val` is high |
| rdy_oe | output | 1 | Ready line driver enable; 0 = released (high impedance) |
| rdy_val | output | 1 | Ready line level while driven: 0 = stall, 1 = ready |
| ram_free | input | 1 | RAM port available for an access in the next cycle |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM byte address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after `ram_re` |

## Verification
The main check is a sequence of byte and word accesses.

- **Read runs.** Sequential read runs at one address separate a hit (no stall, fixed latency) from a miss (stall, then a reload).
- **Read jumps.** A jump to a distant address shows whether stale prefetched bytes are discarded.
- **Direction changes.** Writes followed by reads of the same bytes test both the flush on a change of direction and the little-endian byte order.
- **Address wrap.** An access pair that straddles the top of the address space tests counter wrap.
- **RAM port withheld.** With `ram_free` held low, three cases are tried:
  - a word write that finds only one free slot;
  - a write miss that finds posted bytes;
  - a read miss that finds no data.

  These show the stall, the absence of any RAM access, and the write order once the port returns.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_WAIT = 2'd1,
    ACC_DONE = 2'd2
  } acc_st_e;
endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] shreg;
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-2:0], d[i]};
      end
      assign q[i] = shreg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hbc_fifo.sv
module hbc_fifo #(
  parameter  int DEPTH = 4,
  parameter  int DW    = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [1:0]    push_n,
  input  logic [DW-1:0] push_d0,
  input  logic [DW-1:0] push_d1,
  input  logic [1:0]    pop_n,
  output logic [DW-1:0] head0,
  output logic [DW-1:0] head1,
  output logic [CW-1:0] count
);
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW-1:0] wptr_nx, rptr_nx;

  assign wptr_nx = wptr + 1'b1;
  assign rptr_nx = rptr + 1'b1;

  // storage: no reset, so it maps onto plain memory
  always_ff @(posedge clk) begin
    if (!clr) begin
      if (push_n != 2'd0) store[wptr]    <= push_d0;
      if (push_n == 2'd2) store[wptr_nx] <= push_d1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + PW'(push_n);
      rptr  <= rptr + PW'(pop_n);
      count <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  assign head0 = store[rptr];
  assign head1 = store[rptr_nx];

  // R6
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (int'(count) + int'(push_n)) <= (DEPTH + int'(pop_n)));

  // R11
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |-> int'(pop_n) <= int'(count));
endmodule

// File: rtl/hbc_ctrl.sv
module hbc_ctrl
  import hbc_pkg::*;
#(
  parameter  int AW    = 10,
  parameter  int DW    = 8,
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int HW    = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_act,
  input  logic          wr_act,
  input  logic          host_word,
  input  logic [AW-1:0] host_addr,
  input  logic [HW-1:0] host_wdata,
  output logic [HW-1:0] host_rdata,
  output logic          rdy_oe,
  output logic          rdy_val,
  input  logic          ram_free,
  output logic          ram_re,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  input  logic [CW-1:0] fifo_count,
  input  logic [DW-1:0] head0,
  input  logic [DW-1:0] head1,
  output logic          fifo_clr,
  output logic [1:0]    push_n,
  output logic [DW-1:0] push_d0,
  output logic [DW-1:0] push_d1,
  output logic [1:0]    pop_n
);
  dir_e    dir_q;
  acc_st_e st_q, st_d;
  logic          cnt_ok_q;
  logic [AW-1:0] hcnt_q, bcnt_q;
  logic          ret_q;

  logic       act, is_wr, live, matched;
  logic       rd_req, wr_req, rd_hit, wr_hit;
  logic       flush_wait, reload, rd_svc, wr_svc, svc;
  logic       issue, drain, ret_push, room;
  logic [1:0] need;

  assign act   = rd_act | wr_act;
  assign is_wr = wr_act;
  assign live  = act && (st_q != ACC_DONE);
  assign need  = host_word ? 2'd2 : 2'd1;

  assign matched = cnt_ok_q && (host_addr == hcnt_q);
  assign rd_req  = live && !is_wr;
  assign wr_req  = live && is_wr;
  assign rd_hit  = rd_req && (dir_q == DIR_RD) && matched;
  assign wr_hit  = wr_req && (dir_q == DIR_WR) && matched;

  // any miss while posted data is pending waits for the flush
  assign flush_wait = ((rd_req && !rd_hit) || (wr_req && !wr_hit)) &&
                      (dir_q == DIR_WR) && (fifo_count != '0);
  assign reload = ((rd_req && !rd_hit) || (wr_req && !wr_hit)) && !flush_wait;

  assign rd_svc = rd_hit && (int'(fifo_count) >= int'(need));
  assign wr_svc = wr_hit && ((DEPTH - int'(fifo_count)) >= int'(need));
  assign svc    = rd_svc || wr_svc;

  // read direction: fetch ahead while the FIFO, counting bytes in flight, has room
  assign room  = (int'(fifo_count) + int'(ram_re) + int'(ret_q)) < DEPTH;
  assign issue = (dir_q == DIR_RD) && cnt_ok_q && !reload && ram_free && room;

  // write direction: drain one posted byte per free RAM cycle
  assign drain = (dir_q == DIR_WR) && (fifo_count != '0) && ram_free && !reload;

  assign ret_push = ret_q && (dir_q == DIR_RD) && !reload;

  assign fifo_clr = reload;
  assign push_n   = wr_svc ? need : (ret_push ? 2'd1 : 2'd0);
  assign push_d0  = wr_svc ? host_wdata[DW-1:0] : ram_rdata;
  assign push_d1  = host_wdata[HW-1:DW];
  assign pop_n    = rd_svc ? need : (drain ? 2'd1 : 2'd0);

  always_comb begin
    if (!act)                 st_d = ACC_IDLE;
    else if (svc)             st_d = ACC_DONE;
    else if (st_q == ACC_DONE) st_d = ACC_DONE;
    else                      st_d = ACC_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ACC_IDLE;
      rdy_oe   <= 1'b0;
      rdy_val  <= 1'b0;
      dir_q    <= DIR_RD;
      cnt_ok_q <= 1'b0;
      hcnt_q   <= '0;
      bcnt_q   <= '0;
      ret_q    <= 1'b0;
      ram_re   <= 1'b0;
      ram_we   <= 1'b0;
      ram_addr <= '0;
      ram_wdata <= '0;
      host_rdata <= '0;
    end else begin
      st_q    <= st_d;
      rdy_oe  <= (st_d != ACC_IDLE);
      rdy_val <= (st_d == ACC_DONE);

      if (reload) begin
        dir_q    <= is_wr ? DIR_WR : DIR_RD;
        cnt_ok_q <= 1'b1;
        hcnt_q   <= host_addr;
        bcnt_q   <= host_addr;
      end else begin
        if (svc)            hcnt_q <= hcnt_q + AW'(need);
        if (issue || drain) bcnt_q <= bcnt_q + 1'b1;
      end

      ram_re <= issue;
      ram_we <= drain;
      ret_q  <= ram_re && !reload;
      if (issue || drain) ram_addr <= bcnt_q;
      if (drain)          ram_wdata <= head0;

      if (rd_svc)
        host_rdata <= {(host_word ? head1 : {DW{1'b0}}), head0};
    end
  end

  // R12
  ram_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_re || ram_we) |-> $past(ram_free));

  // R8
  wr_reload_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (reload && dir_q == DIR_WR) |-> (fifo_count == '0));

  // R3
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_val && act) |=> rdy_val);

  // R5
  host_step_chk: assert property (@(posedge clk) disable iff (rst)
    svc |=> (hcnt_q == $past(hcnt_q) + AW'($past(need))));
endmodule

// File: rtl/hbc_cache.sv
module hbc_cache #(
  parameter  int AW          = 10,
  parameter  int DW          = 8,
  parameter  int DEPTH       = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int CW          = $clog2(DEPTH + 1),
  localparam int HW          = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_word,
  input  logic [AW-1:0] host_addr,
  input  logic [HW-1:0] host_wdata,
  output logic [HW-1:0] host_rdata,
  output logic          rdy_oe,
  output logic          rdy_val,
  input  logic          ram_free,
  output logic          ram_re,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  logic [1:0]    strb_s;
  logic [CW-1:0] f_count;
  logic [DW-1:0] f_head0, f_head1, f_d0, f_d1;
  logic          f_clr;
  logic [1:0]    f_push, f_pop;

  hbc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_wr, host_rd}),
    .q   (strb_s)
  );

  hbc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .clr     (f_clr),
    .push_n  (f_push),
    .push_d0 (f_d0),
    .push_d1 (f_d1),
    .pop_n   (f_pop),
    .head0   (f_head0),
    .head1   (f_head1),
    .count   (f_count)
  );

  hbc_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rd_act     (strb_s[0]),
    .wr_act     (strb_s[1]),
    .host_word  (host_word),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .rdy_oe     (rdy_oe),
    .rdy_val    (rdy_val),
    .ram_free   (ram_free),
    .ram_re     (ram_re),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata),
    .fifo_count (f_count),
    .head0      (f_head0),
    .head1      (f_head1),
    .fifo_clr   (f_clr),
    .push_n     (f_push),
    .push_d0    (f_d0),
    .push_d1    (f_d1),
    .pop_n      (f_pop)
  );
endmodule

// File: tb/hbc_cache_tb_top.sv
module hbc_cache_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW  = 10;
  localparam int DW  = 8;
  localparam int HW  = 16;
  localparam int MSZ = 1 << AW;
  localparam int NV  = 14;

  // {wr[39:36], word[35:32], addr[31:20], data[19:4], no_stall[3:0]}
  localparam logic [39:0] VEC [NV] = '{
    40'h0_0_010_0000_0, 40'h0_1_011_0000_1, 40'h0_0_013_0000_1,
    40'h0_1_014_0000_1, 40'h0_0_100_0000_0, 40'h1_1_200_BEEF_0,
    40'h1_0_202_005A_1, 40'h1_1_203_1234_1, 40'h0_1_200_0000_0,
    40'h0_1_202_0000_1, 40'h0_0_204_0000_1, 40'h1_0_3FF_0077_0,
    40'h1_1_000_6655_1, 40'h0_1_3FF_0000_0
  };

  logic clk = 1'b0;
  logic rst;
  logic host_rd, host_wr, host_word;
  logic [AW-1:0] host_addr;
  logic [HW-1:0] host_wdata, host_rdata;
  logic rdy_oe, rdy_val;
  logic ram_free, ram_re, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  logic [DW-1:0] bench_mem [MSZ];
  logic [DW-1:0] model_mem [MSZ];
  logic [AW-1:0] wlog [64];
  int re_cnt = 0, wcnt = 0, bad_free = 0;
  logic free_prev = 1'b0;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  hbc_cache dut_i (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_word(host_word), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rdy_oe(rdy_oe), .rdy_val(rdy_val),
    .ram_free(ram_free), .ram_re(ram_re), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // buffer RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (ram_we) begin
      bench_mem[ram_addr] <= ram_wdata;
      wlog[wcnt % 64] <= ram_addr;
      wcnt++;
    end
    if (ram_re) begin
      ram_rdata <= bench_mem[ram_addr];
      re_cnt++;
    end
    if ((ram_re || ram_we) && !free_prev) bad_free++;
    free_prev <= ram_free;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic h_start(input bit wr, input bit word, input int addr, input int data);
    @(negedge clk);
    host_addr  = AW'(addr);
    host_word  = word;
    host_wdata = HW'(data);
    host_wr    = wr;
    host_rd    = !wr;
  endtask

  task automatic h_wait(output int lat, output bit stalled);
    lat = 0;
    stalled = 1'b0;
    while (!rdy_val && lat < 200) begin
      @(negedge clk);
      lat++;
      if (rdy_oe && !rdy_val) stalled = 1'b1;
    end
  endtask

  task automatic h_end();
    host_rd = 1'b0;
    host_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(rdy_val == 1'b1, "R3 ready held until strobe seen low", int'(rdy_val), 1);
    @(negedge clk);
    chk(!rdy_oe && !rdy_val, "R3 ready released", int'({rdy_oe, rdy_val}), 0);
  endtask

  function automatic int exp_read(input bit word, input int addr);
    int a0 = addr & (MSZ - 1);
    int a1 = (addr + 1) & (MSZ - 1);
    return word ? int'({model_mem[a1], model_mem[a0]}) : int'(model_mem[a0]);
  endfunction

  task automatic post_write(input bit word, input int addr, input int data);
    model_mem[addr & (MSZ - 1)] = data[7:0];
    if (word) model_mem[(addr + 1) & (MSZ - 1)] = data[15:8];
  endtask

  task automatic do_op(input bit wr, input bit word, input int addr, input int data, input bit ns);
    int lat;
    bit st;
    int exp;
    h_start(wr, word, addr, data);
    h_wait(lat, st);
    chk(lat < 200, "R3 access completes", lat, 0);
    if (ns) chk(!st && lat == 3, "R4 R7 hit without stall", lat, 3);
    else    chk(st, "R3 stall on miss", int'(st), 1);
    if (!wr) begin
      exp = exp_read(word, addr);
      chk(int'(host_rdata) == exp, "R2 R5 R9 R10 read data", int'(host_rdata), exp);
    end else begin
      post_write(word, addr, data);
    end
    h_end();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    int lat, base, w0, mism;
    bit st;
    for (int i = 0; i < MSZ; i++) begin
      bench_mem[i] = 8'((i * 7 + 3) & 8'hFF);
      model_mem[i] = 8'((i * 7 + 3) & 8'hFF);
    end
    rst = 1'b1; host_rd = 1'b0; host_wr = 1'b0; host_word = 1'b0;
    host_addr = '0; host_wdata = '0; ram_free = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    // R1 reset and idle state
    chk(!rdy_oe && !rdy_val && !ram_re && !ram_we, "R1 outputs after reset",
        int'({rdy_oe, rdy_val, ram_re, ram_we}), 0);
    chk(re_cnt == 0, "R1 no fetch before first read", re_cnt, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_op(VEC[v][36], VEC[v][32], int'(VEC[v][31:20]), int'(VEC[v][19:4]), VEC[v][0]);
    end

    // R12 and R6: read miss while the RAM port is withheld
    ram_free = 1'b0;
    repeat (6) @(negedge clk);
    base = re_cnt;
    h_start(1'b0, 1'b0, 'h080, 0);
    repeat (12) @(negedge clk);
    chk(rdy_oe && !rdy_val, "R3 R12 stall with RAM withheld", int'({rdy_oe, rdy_val}), 2);
    chk(re_cnt == base, "R12 no RAM read while withheld", re_cnt - base, 0);
    ram_free = 1'b1;
    h_wait(lat, st);
    chk(int'(host_rdata) == exp_read(1'b0, 'h080), "R2 data after release",
        int'(host_rdata), exp_read(1'b0, 'h080));
    h_end();
    repeat (20) @(negedge clk);
    chk(re_cnt - base == 5, "R6 prefetch depth", re_cnt - base, 5);

    // R11: word write with one free slot
    ram_free = 1'b0;
    do_op(1'b1, 1'b0, 'h300, 'h11, 1'b0);
    do_op(1'b1, 1'b1, 'h301, 'h3322, 1'b1);
    w0 = wcnt;
    h_start(1'b1, 1'b1, 'h303, 'h5544);
    repeat (10) @(negedge clk);
    chk(rdy_oe && !rdy_val, "R11 word write needs two slots", int'({rdy_oe, rdy_val}), 2);
    chk(wcnt == w0, "R12 no RAM write while withheld", wcnt - w0, 0);
    ram_free = 1'b1;
    h_wait(lat, st);
    chk(lat < 200, "R11 word write completes", lat, 0);
    post_write(1'b1, 'h303, 'h5544);
    h_end();
    repeat (20) @(negedge clk);

    // R8: write miss with posted bytes
    ram_free = 1'b0;
    do_op(1'b1, 1'b0, 'h310, 'h01, 1'b0);
    do_op(1'b1, 1'b0, 'h311, 'h02, 1'b1);
    w0 = wcnt;
    h_start(1'b1, 1'b0, 'h320, 'h03);
    repeat (10) @(negedge clk);
    chk(rdy_oe && !rdy_val, "R8 write miss stalls", int'({rdy_oe, rdy_val}), 2);
    chk(wcnt == w0, "R8 nothing written while withheld", wcnt - w0, 0);
    ram_free = 1'b1;
    h_wait(lat, st);
    chk(lat < 200, "R8 write miss completes", lat, 0);
    post_write(1'b0, 'h320, 'h03);
    h_end();
    repeat (20) @(negedge clk);
    chk(int'(wlog[w0 % 64]) == 'h310, "R8 flush order first", int'(wlog[w0 % 64]), 'h310);
    chk(int'(wlog[(w0 + 1) % 64]) == 'h311, "R8 flush order second", int'(wlog[(w0 + 1) % 64]), 'h311);
    chk(int'(wlog[(w0 + 2) % 64]) == 'h320, "R8 new address after flush", int'(wlog[(w0 + 2) % 64]), 'h320);

    // R7 RAM image
    mism = 0;
    for (int i = 0; i < MSZ; i++) if (bench_mem[i] !== model_mem[i]) mism++;
    chk(mism == 0, "R7 RAM image matches writes", mism, 0);
    chk(bad_free == 0, "R12 accesses only after ram_free", bad_free, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule